// File: doc/BRIEF.md
# Codec Link Global Control and Access Semaphore

This block is the global control and status section of an audio controller whose serial link can carry up to three codecs. Software programs the sample width, the channel count and the interrupt enables through one control word. The same word holds the link shut-off bit and the two link reset controls. The cold-reset control drives the link reset output directly. The warm-reset request starts a timed pulse on the link, and its bit clears itself when the pulse ends.

A status word reports three things. The first is which codec inputs report ready. The second is which of them came back after a warm reset; these are sticky events that software clears by writing ones. The third is live summaries of the per-channel interrupts. A one-bit semaphore serialises software access to the codec mixer registers. Reading it claims it when free, and the codec-access-done strobe releases it.

All registers are reached through one 32-bit port. Reads are combinational on the address. Writes, and the side effect of reading the semaphore, take effect at the clock edge where the enable is high.

Top module: `codec_link_ctrl`

## Requirements
- R1: After reset the control word (0x2C) and the semaphore word (0x34) read 0. `link_cold_rst_n_o` is low. The status word (0x30) shows only its capability bits and the live input summaries.
- R2: Writing the control word stores the following fields, which read back: sample width [23:22], channel count [21:20], resume interrupt enables [6:4] for codec inputs 2..0, link shut-off [3], cold-reset release [1] and GPI interrupt enable [0]. The width, channel and shut-off fields also drive `sample_width_o`, `chan_mode_o` and `link_off_o` from the cycle after the write.
- R3: `link_cold_rst_n_o` equals control bit 1. Writing 0 to it cancels any warm reset in progress at that edge and disarms resume detection.
- R4: A control write that has bit 2 = 1, bit 1 = 1 and bit 3 = 0, made while no warm reset is running, raises `link_warm_rst_o` for exactly WARM_CYCLES cycles, starting in the cycle after the write. Control bit 2 reads 1 for those cycles and 0 otherwise.
- R5: A warm-reset request is ignored in three cases: the same write sets bit 3 to 1, the same write leaves bit 1 at 0, or a warm reset is already running.
- R6: Status bits 8, 9 and 28 show the ready inputs of codecs 0, 1 and 2, one cycle late. Writes do not change them.
- R7: Each codec input has a resume bit at status bit 10, 11 or 29 (codecs 0, 1, 2). When a warm reset completes, all three inputs are armed. The first rising edge of an armed input's ready signal sets its resume bit and disarms that input. Writing 1 to a resume bit clears it. A set in the same cycle as a clear wins.
- R8: Status bit 15 is set by a pulse on `access_tmo_i` and cleared by writing 1 to it. A set in the same cycle wins.
- R9: Status bits 1, 2, 5, 6 and 7 mirror `chan_irq_i[0..4]`. Bit 0 mirrors `gpi_chg_i`. Bits 20 and 21 are the 4-channel and 6-channel capability parameters.
- R10: Semaphore bit 0 (0x34) reads its current value. A read that finds it 0 sets it to 1. `access_done_i` clears it, except that a read finding it 0 in the same cycle still sets it.
- R11: `irq_o` is high when any resume bit is set and its enable is set, or when `gpi_chg_i` is high and the GPI enable is set.
- R12: Any other address reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (semaphore side effect) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| codec_rdy_i | input | 3 | Ready level of codec inputs 0..2 |
| access_done_i | input | 1 | Codec mixer access finished |
| access_tmo_i | input | 1 | Codec read completion timed out |
| chan_irq_i | input | 5 | Channel interrupts: modem-in, modem-out, PCM-in, PCM-out, mic |
| gpi_chg_i | input | 1 | GPI status change |
| link_cold_rst_n_o | output | 1 | Link cold reset, active low |
| link_warm_rst_o | output | 1 | Link warm reset pulse |
| link_off_o | output | 1 | Link shut-off |
| sample_width_o | output | 2 | Selected sample width code |
| chan_mode_o | output | 2 | Selected channel count code |
| irq_o | output | 1 | Global interrupt |

## Verification
The assertions check the following on every cycle:
- a warm reset never starts with the link shut off or held in cold reset;
- a warm reset never runs while cold reset is asserted, and its pulse ends only when the counter runs out;
- a ready flag always equals the previous cycle's input;
- a resume bit rises only on an armed input;
- the semaphore sets on a free read and drops on completion.

Only the bench's scenarios can show the rest: the cycle-by-cycle read values of all three words, including the priority of set over write-one-to-clear and of a claiming read over a completion in the same cycle, that resume events come only after a completed warm reset, and that an abort through the cold-reset bit disarms detection.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
    localparam int NCODEC = 3;
    localparam int NCHAN  = 5;

    localparam logic [7:0] ADDR_CTRL = 8'h2C;
    localparam logic [7:0] ADDR_STAT = 8'h30;
    localparam logic [7:0] ADDR_SEM  = 8'h34;

    // control word positions
    localparam int C_GPI_EN  = 0;
    localparam int C_COLD    = 1;
    localparam int C_WARM    = 2;
    localparam int C_OFF     = 3;
    localparam int C_RES_EN  = 4;
    localparam int C_CHAN_LO = 20;
    localparam int C_WID_LO  = 22;

    // status word positions
    localparam int S_GPI  = 0;
    localparam int S_RCS  = 15;
    localparam int S_CAP4 = 20;
    localparam int S_CAP6 = 21;

    function automatic int rdy_bit(input int i);
        case (i)
            0:       return 8;
            1:       return 9;
            default: return 28;
        endcase
    endfunction

    function automatic int res_bit(input int i);
        case (i)
            0:       return 10;
            1:       return 11;
            default: return 29;
        endcase
    endfunction

    function automatic int chan_bit(input int i);
        case (i)
            0:       return 1;
            1:       return 2;
            2:       return 5;
            3:       return 6;
            default: return 7;
        endcase
    endfunction

    typedef struct packed {
        logic [1:0]        width;
        logic [1:0]        chan;
        logic [NCODEC-1:0] res_en;
        logic              gpi_en;
    } gctl_t;
endpackage

// File: rtl/link_reset_seq.sv
module link_reset_seq #(
    parameter int WARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic cold_rel_wr_i,
    input  logic off_wr_i,
    input  logic warm_req_wr_i,
    output logic cold_rel_o,
    output logic link_off_o,
    output logic warm_busy_o,
    output logic warm_done_o,
    output logic cold_drop_o
);
    localparam int CW = $clog2(WARM_CYCLES + 1);

    typedef struct packed {
        logic          cold;
        logic          off;
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic done_d;

    always_comb begin
        s_d    = s_q;
        done_d = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                done_d   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (ctrl_wr_i) begin
            s_d.cold = cold_rel_wr_i;
            s_d.off  = off_wr_i;
            if (warm_req_wr_i && !off_wr_i && cold_rel_wr_i && !s_q.busy) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CW'(WARM_CYCLES - 1);
            end
        end
        if (!s_d.cold) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
            done_d   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cold_rel_o  = s_q.cold;
    assign link_off_o  = s_q.off;
    assign warm_busy_o = s_q.busy;
    assign warm_done_o = done_d;
    assign cold_drop_o = ctrl_wr_i && !cold_rel_wr_i;

    assert_warm_start_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (!s_q.off && s_q.cold));
    assert_no_warm_in_cold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cold |-> !s_q.busy);
    assert_warm_end_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.busy) && s_q.cold) |-> ($past(s_q.cnt) == '0));
endmodule

// File: rtl/codec_event_status.sv
module codec_event_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rdy_i,
    input  logic         warm_done_i,
    input  logic         cold_rel_i,
    input  logic         cold_drop_i,
    input  logic         tmo_i,
    input  logic         stat_wr_i,
    input  logic [N-1:0] clr_res_i,
    input  logic         clr_rcs_i,
    output logic [N-1:0] rdy_o,
    output logic [N-1:0] res_o,
    output logic         rcs_o
);
    typedef struct packed {
        logic [N-1:0] rdy;
        logic [N-1:0] arm;
        logic [N-1:0] res;
        logic         rcs;
    } ev_t;

    ev_t e_d, e_q;
    logic [N-1:0] hit;

    always_comb begin
        e_d     = e_q;
        e_d.rdy = rdy_i;
        hit     = rdy_i & ~e_q.rdy & e_q.arm;
        if (stat_wr_i) begin
            e_d.res = e_q.res & ~clr_res_i;
            e_d.rcs = e_q.rcs & ~clr_rcs_i;
        end
        e_d.res = e_d.res | hit;
        e_d.rcs = e_d.rcs | tmo_i;
        e_d.arm = e_q.arm & ~hit;
        if (warm_done_i) e_d.arm = '1;
        if (!cold_rel_i || cold_drop_i) e_d.arm = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign rdy_o = e_q.rdy;
    assign res_o = e_q.res;
    assign rcs_o = e_q.rcs;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_rdy_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (e_q.rdy[g] == $past(rdy_i[g])));
        assert_resume_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(e_q.res[g]) |-> $past(e_q.arm[g]));
    end
endmodule

// File: rtl/codec_access_sem.sv
module codec_access_sem (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit_i,
    input  logic done_i,
    output logic sem_o
);
    logic sem_d, sem_q;

    always_comb begin
        if (sem_q) sem_d = !done_i;
        else       sem_d = rd_hit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sem_q <= 1'b0;
        else        sem_q <= sem_d;
    end

    assign sem_o = sem_q;

    assert_sem_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && !sem_o) |=> sem_o);
    assert_sem_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && sem_o) |=> !sem_o);
endmodule

// File: rtl/codec_link_ctrl.sv
module codec_link_ctrl
    import codec_link_pkg::*;
#(
    parameter int WARM_CYCLES = 4,
    parameter bit HAS_4CH     = 1'b1,
    parameter bit HAS_6CH     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  addr_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    input  logic [2:0]  codec_rdy_i,
    input  logic        access_done_i,
    input  logic        access_tmo_i,
    input  logic [4:0]  chan_irq_i,
    input  logic        gpi_chg_i,
    output logic        link_cold_rst_n_o,
    output logic        link_warm_rst_o,
    output logic        link_off_o,
    output logic [1:0]  sample_width_o,
    output logic [1:0]  chan_mode_o,
    output logic        irq_o
);
    gctl_t g_d, g_q;
    logic wr_ctrl, wr_stat, rd_sem;
    logic cold_rel, warm_busy, warm_done, cold_drop, sem;
    logic [NCODEC-1:0] rdy, res, clr_res;
    logic rcs;
    logic [31:0] ctrl_word, stat_word;
    logic unused_wbits;

    assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
    assign rd_sem  = rd_en_i && (addr_i == ADDR_SEM);

    always_comb begin
        g_d = g_q;
        if (wr_ctrl) begin
            g_d.width  = wdata_i[C_WID_LO +: 2];
            g_d.chan   = wdata_i[C_CHAN_LO +: 2];
            g_d.res_en = wdata_i[C_RES_EN +: NCODEC];
            g_d.gpi_en = wdata_i[C_GPI_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    link_reset_seq #(.WARM_CYCLES(WARM_CYCLES)) rst_seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr_i     (wr_ctrl),
        .cold_rel_wr_i (wdata_i[C_COLD]),
        .off_wr_i      (wdata_i[C_OFF]),
        .warm_req_wr_i (wdata_i[C_WARM]),
        .cold_rel_o    (cold_rel),
        .link_off_o    (link_off_o),
        .warm_busy_o   (warm_busy),
        .warm_done_o   (warm_done),
        .cold_drop_o   (cold_drop)
    );

    for (genvar c = 0; c < NCODEC; c++) begin : g_clr
        assign clr_res[c] = wdata_i[res_bit(c)];
    end

    codec_event_status #(.N(NCODEC)) ev_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rdy_i       (codec_rdy_i),
        .warm_done_i (warm_done),
        .cold_rel_i  (cold_rel),
        .cold_drop_i (cold_drop),
        .tmo_i       (access_tmo_i),
        .stat_wr_i   (wr_stat),
        .clr_res_i   (clr_res),
        .clr_rcs_i   (wdata_i[S_RCS]),
        .rdy_o       (rdy),
        .res_o       (res),
        .rcs_o       (rcs)
    );

    codec_access_sem sem_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit_i (rd_sem),
        .done_i   (access_done_i),
        .sem_o    (sem)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[C_WID_LO +: 2]      = g_q.width;
        ctrl_word[C_CHAN_LO +: 2]     = g_q.chan;
        ctrl_word[C_RES_EN +: NCODEC] = g_q.res_en;
        ctrl_word[C_OFF]              = link_off_o;
        ctrl_word[C_WARM]             = warm_busy;
        ctrl_word[C_COLD]             = cold_rel;
        ctrl_word[C_GPI_EN]           = g_q.gpi_en;
    end

    always_comb begin
        stat_word = '0;
        for (int c = 0; c < NCODEC; c++) begin
            stat_word[rdy_bit(c)] = rdy[c];
            stat_word[res_bit(c)] = res[c];
        end
        for (int k = 0; k < NCHAN; k++) stat_word[chan_bit(k)] = chan_irq_i[k];
        stat_word[S_GPI]  = gpi_chg_i;
        stat_word[S_RCS]  = rcs;
        stat_word[S_CAP4] = HAS_4CH;
        stat_word[S_CAP6] = HAS_6CH;
    end

    always_comb begin
        case (addr_i)
            ADDR_CTRL: rdata_o = ctrl_word;
            ADDR_STAT: rdata_o = stat_word;
            ADDR_SEM:  rdata_o = {31'b0, sem};
            default:   rdata_o = '0;
        endcase
    end

    assign link_cold_rst_n_o = cold_rel;
    assign link_warm_rst_o   = warm_busy;
    assign sample_width_o    = g_q.width;
    assign chan_mode_o       = g_q.chan;
    assign irq_o             = (|(res & g_q.res_en)) || (gpi_chg_i && g_q.gpi_en);

    assign unused_wbits = ^{wdata_i[31:30], wdata_i[28:24], wdata_i[19:16],
                            wdata_i[14:12], wdata_i[9:7]};
endmodule

// File: tb/codec_link_ctrl_tb_top.sv
module codec_link_ctrl_tb_top;
    localparam int WARM = 4;
    localparam bit CAP4 = 1'b1;
    localparam bit CAP6 = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  rdy = '0;
    logic        done = 1'b0, tmo = 1'b0, gpi = 1'b0;
    logic [4:0]  chan = '0;
    logic        cold_n, warm, off, irq;
    logic [1:0]  width, chmode;

    always #2 clk = ~clk;

    codec_link_ctrl #(.WARM_CYCLES(WARM), .HAS_4CH(CAP4), .HAS_6CH(CAP6)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .codec_rdy_i(rdy), .access_done_i(done),
        .access_tmo_i(tmo), .chan_irq_i(chan), .gpi_chg_i(gpi),
        .link_cold_rst_n_o(cold_n), .link_warm_rst_o(warm), .link_off_o(off),
        .sample_width_o(width), .chan_mode_o(chmode), .irq_o(irq)
    );

    int n_cmp = 0, n_bad = 0;
    string phase = "R1";

    // behavioural reference state
    int m_width = 0, m_chan = 0, m_en = 0, m_gpien = 0;
    int m_cold = 0, m_off = 0, m_busy = 0, m_left = 0;
    bit m_rdy[3] = '{0, 0, 0};
    bit m_arm[3] = '{0, 0, 0};
    bit m_res[3] = '{0, 0, 0};
    bit m_rcs = 0, m_sem = 0;

    function automatic int rdy_pos(int i); return (i == 2) ? 28 : 8 + i; endfunction
    function automatic int res_pos(int i); return (i == 2) ? 29 : 10 + i; endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = '0;
        if (addr == 8'h2C) begin
            v[23:22] = m_width[1:0]; v[21:20] = m_chan[1:0]; v[6:4] = m_en[2:0];
            v[3] = m_off[0]; v[2] = m_busy[0]; v[1] = m_cold[0]; v[0] = m_gpien[0];
        end else if (addr == 8'h30) begin
            for (int i = 0; i < 3; i++) begin
                v[rdy_pos(i)] = m_rdy[i];
                v[res_pos(i)] = m_res[i];
            end
            v[1] = chan[0]; v[2] = chan[1]; v[5] = chan[2]; v[6] = chan[3]; v[7] = chan[4];
            v[0] = gpi; v[15] = m_rcs; v[20] = CAP4; v[21] = CAP6;
        end else if (addr == 8'h34) begin
            v[0] = m_sem;
        end
        return v;
    endfunction

    function automatic bit exp_irq();
        bit r = gpi && (m_gpien != 0);
        for (int i = 0; i < 3; i++) if (m_res[i] && m_en[i]) r = 1;
        return r;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        string rt;
        if (addr == 8'h2C) rt = "R2";
        else if (addr == 8'h30) rt = "R7";
        else if (addr == 8'h34) rt = "R10";
        else rt = "R12";
        chk(rt, "rdata", rdata, exp_rdata());
        chk("R3", "cold_rst_n", cold_n, m_cold);
        chk("R4", "warm_rst", warm, m_busy);
        chk("R2", "link_off", off, m_off);
        chk("R2", "width", width, m_width);
        chk("R2", "chan_mode", chmode, m_chan);
        chk("R11", "irq", irq, exp_irq());
    endtask

    task automatic model_step();
        int n_cold = m_cold, n_off = m_off, n_busy = m_busy, n_left = m_left;
        bit fin = 0;
        bit wc = wr_en && addr == 8'h2C;
        bit ws = wr_en && addr == 8'h30;
        bit n_arm[3];
        bit n_res[3];
        if (m_busy != 0) begin
            if (m_left == 0) begin n_busy = 0; fin = 1; end
            else n_left = m_left - 1;
        end
        if (wc) begin
            n_cold = wdata[1]; n_off = wdata[3];
            m_width = wdata[23:22]; m_chan = wdata[21:20]; m_en = wdata[6:4]; m_gpien = wdata[0];
            if (wdata[2] && !wdata[3] && wdata[1] && m_busy == 0) begin n_busy = 1; n_left = WARM - 1; end
        end
        if (n_cold == 0) begin n_busy = 0; n_left = 0; fin = 0; end
        for (int i = 0; i < 3; i++) begin
            bit rise = rdy[i] && !m_rdy[i];
            n_res[i] = m_res[i];
            if (ws && wdata[res_pos(i)]) n_res[i] = 0;
            n_arm[i] = m_arm[i];
            if (rise && m_arm[i]) begin n_res[i] = 1; n_arm[i] = 0; end
            if (fin) n_arm[i] = 1;
            if (m_cold == 0 || (wc && !wdata[1])) n_arm[i] = 0;
        end
        if (ws && wdata[15]) m_rcs = 0;
        if (tmo) m_rcs = 1;
        if (rd_en && addr == 8'h34 && !m_sem) m_sem = 1;
        else if (done) m_sem = 0;
        for (int i = 0; i < 3; i++) begin
            m_rdy[i] = rdy[i]; m_arm[i] = n_arm[i]; m_res[i] = n_res[i];
        end
        m_cold = n_cold; m_off = n_off; m_busy = n_busy; m_left = n_left;
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; rd_en = 0; done = 0; tmo = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1; tick();
    endtask

    task automatic rd(logic [7:0] a);
        addr = a; rd_en = 1; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values of every register
        phase = "R1";
        rd(8'h2C); rd(8'h30); addr = 8'h34; tick();
        // R2: field store and readback, link still in cold reset
        phase = "R2";
        wr(8'h2C, 32'h00D0_0071); rd(8'h2C); idle(2);
        // R5: warm request with cold bit 0, then with shut-off set
        phase = "R5";
        wr(8'h2C, 32'h0000_0004); idle(WARM + 2);
        wr(8'h2C, 32'h0000_000E); idle(WARM + 2);
        // R3: cold release
        phase = "R3";
        wr(8'h2C, 32'h0000_0072); idle(2);
        // R4/R7: warm reset, ready rises during it (not counted), then after
        phase = "R4";
        wr(8'h2C, 32'h0000_0076);
        rdy = 3'b001; addr = 8'h30; idle(2);
        // R5: second request while busy ignored
        wr(8'h2C, 32'h0000_0076); addr = 8'h30; idle(WARM + 1);
        phase = "R7";
        rdy = 3'b000; idle(1);
        rdy = 3'b011; idle(2);
        rdy = 3'b010; idle(1);
        rdy = 3'b011; idle(2);            // second edge after one event: no new set
        // R7: clear codec0 while codec2 rises (codec2 set)
        rdy = 3'b111; wr(8'h30, 32'h0000_0400); addr = 8'h30; idle(2);
        // set-wins: arm again, clear codec1 bit on its rising edge cycle
        rdy = 3'b000; wr(8'h2C, 32'h0000_0076); addr = 8'h30; idle(WARM + 1);
        rdy = 3'b010; wr(8'h30, 32'h0000_0800); addr = 8'h30; idle(2);
        wr(8'h30, 32'h2000_0C00); addr = 8'h30; idle(1);
        // R6: status writes do not alter ready flags
        phase = "R6";
        wr(8'h30, 32'hFFFF_FFFF); addr = 8'h30; idle(1);
        // R8: timeout set, clear, simultaneous set+clear
        phase = "R8";
        tmo = 1; addr = 8'h30; tick(); idle(1);
        wr(8'h30, 32'h0000_8000); addr = 8'h30; idle(1);
        tmo = 1; wr(8'h30, 32'h0000_8000); addr = 8'h30; idle(1);
        wr(8'h30, 32'h0000_8000);
        // R9: live channel and GPI summaries
        phase = "R9";
        addr = 8'h30;
        chan = 5'b10101; idle(1); chan = 5'b01010; gpi = 1; idle(1); chan = 0; gpi = 0; idle(1);
        // R11: interrupt combinations
        phase = "R11";
        wr(8'h2C, 32'h0000_0003); gpi = 1; idle(1); gpi = 0; idle(1);
        rdy = 3'b000; wr(8'h2C, 32'h0000_0076); idle(WARM + 1);
        rdy = 3'b100; idle(2);
        wr(8'h2C, 32'h0000_0032); idle(1);
        wr(8'h2C, 32'h0000_0042); idle(1);
        wr(8'h30, 32'h2000_0000); idle(1);
        // R3: abort a warm reset by dropping cold release
        phase = "R3";
        rdy = 3'b000; wr(8'h2C, 32'h0000_0006); idle(1);
        wr(8'h2C, 32'h0000_0000); idle(WARM + 2);
        wr(8'h2C, 32'h0000_0002); rdy = 3'b111; addr = 8'h30; idle(2);
        // R10: semaphore claim, reread, release, race cases
        phase = "R10";
        rd(8'h34); rd(8'h34); addr = 8'h34; idle(1);
        done = 1; addr = 8'h34; tick(); idle(1);
        done = 1; rd(8'h34); idle(1);      // free + read + done: stays set
        done = 1; rd(8'h34); idle(1);      // set + read + done: released
        rd(8'h30); addr = 8'h34; idle(1);  // read of other word: no claim
        // R12: other addresses
        phase = "R12";
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h38); addr = 8'h2C; idle(1); addr = 8'h30; idle(1);
        wr(8'h2E, 32'hFFFF_FFFF); addr = 8'h2C; idle(1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule